// File: doc/BRIEF.md
# DMA Transfer Sequencer with Selectable Termination

This block runs one peripheral-side DMA transfer at a time. Software programs a small configuration word, a byte count and then a command opcode over a four-address write port. The command starts the transfer at once: the request output rises on the next cycle and stays high until a termination source fires. While the request is high, the data path reports each accepted beat on `beat_i`. The block counts those beats down in bytes, two per beat on a 16-bit bus and one per beat on an 8-bit bus.

Two families of transfer exist. A slave (generic) transfer can run with its byte counter enabled, or in an end-of-transfer-only mode where the counter is frozen and only events stop it. A master transfer always counts and ignores the external end-of-transfer pin. A transfer can end when the count reaches zero, when the external pin fires, when a short packet is seen, or when a stop opcode is written. Each of the first three sources sets its own sticky reason bit, and software clears these bits by writing ones. The strobe selection, bus width, direction and master flag are captured when the transfer starts and drive the data-path strobes for its whole length.

Top module: `dma_term_ctrl`

## Requirements
- R1: Writing opcode 00h (slave read), 01h (slave write), 06h (master read) or 07h (master write) to address 2 while idle raises `dma_req_o` on the next cycle. Any other opcode written while idle leaves the block idle.
- R2: At start the block captures config bits [2:1] into `strobe_sel_o` and bit 3 into `bus16_o`. It sets `ata_mode_o` to 1 for a master opcode and 0 for a slave opcode, and sets `dir_wr_o` from opcode bit 0. These outputs do not change while the transfer runs, even if the config is rewritten.
- R3: A write to address 1 while idle loads the count shown on `count_o`. Each counted beat lowers it by 2 when `bus16_o` is 1 and by 1 otherwise, and the count stops at 0.
- R4: With counting active (master, or slave with config bit 0 clear), the beat that brings the count to zero ends the transfer and sets reason bit 2 (complete).
- R5: In slave end-of-transfer-only mode (config bit 0 set), beats leave `count_o` unchanged and never end the transfer.
- R6: `ext_eot_i` ends a running slave transfer and sets reason bit 1. In master mode, and while idle, it has no effect.
- R7: `short_pkt_i` ends a running transfer in either mode and sets reason bit 0. While idle it has no effect.
- R8: Opcode 0Fh written while running ends the transfer and sets no reason bit.
- R9: When several termination sources fire in the same cycle, every matching reason bit is set.
- R10: Reason bits stay set until a write to address 3 with a one in their position. A bit that is set and cleared in the same cycle ends up set. `irq_o` is the OR of the reason bits.
- R11: After a termination `dma_req_o` is low on the next cycle, and a command written in that cycle is accepted. Command writes other than stop, and count writes, are ignored while a transfer runs.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 config, 1 count, 2 command, 3 reason clear |
| reg_wdata | input | DATA_W | Write data |
| beat_i | input | 1 | One data beat accepted this cycle |
| ext_eot_i | input | 1 | External end-of-transfer pulse |
| short_pkt_i | input | 1 | Short packet seen (internal end of transfer) |
| dma_req_o | output | 1 | Transfer running / DMA request |
| dir_wr_o | output | 1 | 1 for a write transfer |
| ata_mode_o | output | 1 | 1 for a master transfer |
| strobe_sel_o | output | 2 | Active data-strobe selection |
| bus16_o | output | 1 | 1 for a 16-bit bus |
| count_o | output | DATA_W | Remaining byte count |
| irq_reason_o | output | 3 | Sticky reasons: bit0 short packet, bit1 external, bit2 complete |
| irq_o | output | 1 | Any reason bit set |

## Verification
A wrong run state shows up on `dma_req_o` one cycle after the beat, pin or write that should have changed it. A wrong captured mode shows up as an early or late end together with a wrong reason bit. A counter fault, such as a wrong step, wrapping below zero or counting in end-of-transfer-only mode, shows on `count_o` one cycle after the beat. In counted mode it also moves the completion to the wrong beat. The stimulus is arranged so that each termination source, and each source that should be ignored, changes at least one of `dma_req_o`, `count_o` or `irq_reason_o` in the cycle after it is applied.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_CMD = 2'd2;
  localparam logic [1:0] A_RSN = 2'd3;

  localparam logic [7:0] OP_SRD  = 8'h00;
  localparam logic [7:0] OP_SWR  = 8'h01;
  localparam logic [7:0] OP_MRD  = 8'h06;
  localparam logic [7:0] OP_MWR  = 8'h07;
  localparam logic [7:0] OP_STOP = 8'h0F;

  localparam int RSN_W    = 3;
  localparam int RSN_INT  = 0;
  localparam int RSN_EXT  = 1;
  localparam int RSN_DONE = 2;

  localparam int CFG_W     = 4;
  localparam int CFG_NOCNT = 0;
  localparam int CFG_SSEL  = 1;
  localparam int CFG_WIDE  = 3;

  typedef enum logic {ST_IDLE, ST_RUN} xfer_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic dir_wr;
    logic master;
  } cmd_dec_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_term_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_dec_t   dec_o
);
  always_comb begin
    dec_o = '0;
    case (op_i)
      OP_SRD:  begin dec_o.start = 1'b1; end
      OP_SWR:  begin dec_o.start = 1'b1; dec_o.dir_wr = 1'b1; end
      OP_MRD:  begin dec_o.start = 1'b1; dec_o.master = 1'b1; end
      OP_MWR:  begin dec_o.start = 1'b1; dec_o.master = 1'b1; dec_o.dir_wr = 1'b1; end
      OP_STOP: begin dec_o.stop  = 1'b1; end
      default: dec_o = '0;
    endcase
  end

  always_comb begin
    assert (!(dec_o.start && dec_o.stop)) else $error("p_decode_excl_r1");
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  input  logic         wide_i,
  output logic [W-1:0] count_o,
  output logic         last_o
);
  localparam logic [W-1:0] STEP_NARROW = W'(1);
  localparam logic [W-1:0] STEP_WIDE   = W'(2);

  logic [W-1:0] step;
  logic [W-1:0] count_q;

  assign step    = wide_i ? STEP_WIDE : STEP_NARROW;
  assign last_o  = dec_i && (count_q <= step);
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (dec_i)  count_q <= last_o ? '0 : count_q - step;
  end

  p_cnt_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i && count_q < step) |=> (count_q == '0));
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!dec_i && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/dma_irq_reason.sv
module dma_irq_reason #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] rsn_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                         rsn_o[i] <= 1'b0;
      else if (set_i[i])               rsn_o[i] <= 1'b1;
      else if (clr_i && clr_mask_i[i]) rsn_o[i] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> rsn_o[i]);
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      (rsn_o[i] && !(clr_i && clr_mask_i[i])) |=> rsn_o[i]);
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              beat_i,
  input  logic              ext_eot_i,
  input  logic              short_pkt_i,
  output logic              dma_req_o,
  output logic              dir_wr_o,
  output logic              ata_mode_o,
  output logic [1:0]        strobe_sel_o,
  output logic              bus16_o,
  output logic [DATA_W-1:0] count_o,
  output logic [RSN_W-1:0]  irq_reason_o,
  output logic              irq_o
);
  xfer_state_t      st_q;
  logic [CFG_W-1:0] cfg_q;
  logic             nocnt_q;
  cmd_dec_t         dec;
  logic running, cfg_we, cnt_we, cmd_we, rsn_we;
  logic start_go, stop_go, count_on, dec_en, cnt_last;
  logic done_ev, ext_ev, int_ev, term;
  logic [RSN_W-1:0] rsn_set;

  assign running = (st_q == ST_RUN);
  assign cfg_we  = reg_we && (reg_addr == A_CFG);
  assign cnt_we  = reg_we && (reg_addr == A_CNT) && !running;
  assign cmd_we  = reg_we && (reg_addr == A_CMD);
  assign rsn_we  = reg_we && (reg_addr == A_RSN);

  dma_cmd_decode u_dec (
    .op_i  (reg_wdata[7:0]),
    .dec_o (dec)
  );

  assign start_go = cmd_we && dec.start && !running;
  assign stop_go  = cmd_we && dec.stop && running;
  assign count_on = ata_mode_o || !nocnt_q;
  assign dec_en   = running && beat_i && count_on;

  dma_xfer_counter #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_we),
    .load_val_i (reg_wdata),
    .dec_i      (dec_en),
    .wide_i     (bus16_o),
    .count_o    (count_o),
    .last_o     (cnt_last)
  );

  assign done_ev = cnt_last;
  assign ext_ev  = running && !ata_mode_o && ext_eot_i;
  assign int_ev  = running && short_pkt_i;
  assign term    = done_ev || ext_ev || int_ev || stop_go;

  always_comb begin
    rsn_set           = '0;
    rsn_set[RSN_INT]  = int_ev;
    rsn_set[RSN_EXT]  = ext_ev;
    rsn_set[RSN_DONE] = done_ev;
  end

  dma_irq_reason #(.N(RSN_W)) u_rsn (
    .clk        (clk),
    .rst        (rst),
    .set_i      (rsn_set),
    .clr_i      (rsn_we),
    .clr_mask_i (reg_wdata[RSN_W-1:0]),
    .rsn_o      (irq_reason_o)
  );

  assign irq_o = |irq_reason_o;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      dir_wr_o     <= 1'b0;
      ata_mode_o   <= 1'b0;
      strobe_sel_o <= 2'b00;
      bus16_o      <= 1'b0;
      nocnt_q      <= 1'b0;
    end else if (start_go) begin
      st_q         <= ST_RUN;
      dir_wr_o     <= dec.dir_wr;
      ata_mode_o   <= dec.master;
      strobe_sel_o <= cfg_q[CFG_SSEL +: 2];
      bus16_o      <= cfg_q[CFG_WIDE];
      nocnt_q      <= cfg_q[CFG_NOCNT];
    end else if (running && term) begin
      st_q <= ST_IDLE;
    end
  end

  assign dma_req_o = running;

  p_end_r11: assert property (@(posedge clk) disable iff (rst)
    (running && term) |=> !dma_req_o);
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |=> $stable({strobe_sel_o, bus16_o, ata_mode_o, dir_wr_o}));
  p_master_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (running && ata_mode_o && !int_ev && !stop_go && !done_ev) |=> dma_req_o);
  p_eot_only_r5: assert property (@(posedge clk) disable iff (rst)
    (running && !ata_mode_o && nocnt_q) |=> $stable(count_o));
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_go && !int_ev && !ext_ev && !done_ev && !rsn_we) |=> $stable(irq_reason_o));
endmodule

// File: tb/dma_term_ctrl_tb_top.sv
module dma_term_ctrl_tb_top;
  localparam int DW = 16;
  localparam int NV = 12;
  // cfg[39:36] cnt[35:28] op[27:20] beats[19:16] ev[15:12] req[11] rsn[10:8] cnt[7:0]
  // ev: 0 none, 1 ext, 2 short, 3 stop, 4 ext+short
  localparam logic [39:0] VEC [NV] = '{
    {4'h0, 8'd4,  8'h00, 4'd4, 4'd0, 1'b0, 3'b100, 8'd0},  // R4 R3 8-bit count to zero
    {4'h8, 8'd6,  8'h01, 4'd2, 4'd0, 1'b1, 3'b000, 8'd2},  // R3 16-bit step
    {4'h8, 8'd5,  8'h00, 4'd3, 4'd0, 1'b0, 3'b100, 8'd0},  // R3 floor at zero
    {4'h1, 8'd2,  8'h00, 4'd5, 4'd0, 1'b1, 3'b000, 8'd2},  // R5 frozen count
    {4'h1, 8'd2,  8'h01, 4'd1, 4'd1, 1'b0, 3'b010, 8'd2},  // R6 ext ends slave
    {4'h1, 8'd9,  8'h00, 4'd0, 4'd2, 1'b0, 3'b001, 8'd9},  // R7 short packet
    {4'h0, 8'd10, 8'h00, 4'd1, 4'd3, 1'b0, 3'b000, 8'd9},  // R8 stop
    {4'h1, 8'd3,  8'h06, 4'd3, 4'd0, 1'b0, 3'b100, 8'd0},  // R4 master counts
    {4'h0, 8'd10, 8'h07, 4'd0, 4'd1, 1'b1, 3'b000, 8'd10}, // R6 master ignores ext
    {4'h0, 8'd10, 8'h06, 4'd0, 4'd2, 1'b0, 3'b001, 8'd10}, // R7 master short
    {4'h0, 8'd10, 8'h03, 4'd0, 4'd0, 1'b0, 3'b000, 8'd10}, // R1 bad opcode
    {4'h0, 8'd10, 8'h00, 4'd0, 4'd4, 1'b0, 3'b011, 8'd10}  // R9 two sources
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic beat_i = 1'b0, ext_eot_i = 1'b0, short_pkt_i = 1'b0;
  logic dma_req_o, dir_wr_o, ata_mode_o, bus16_o, irq_o;
  logic [1:0] strobe_sel_o;
  logic [DW-1:0] count_o;
  logic [2:0] irq_reason_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_term_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .beat_i(beat_i), .ext_eot_i(ext_eot_i), .short_pkt_i(short_pkt_i),
    .dma_req_o(dma_req_o), .dir_wr_o(dir_wr_o), .ata_mode_o(ata_mode_o),
    .strobe_sel_o(strobe_sel_o), .bus16_o(bus16_o), .count_o(count_o),
    .irq_reason_o(irq_reason_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 req", dma_req_o, 0);
    chk("R12 reason", {irq_o, irq_reason_o}, 0);
    chk("R12 count", count_o, 0);
    chk("R12 mode", {ata_mode_o, dir_wr_o, bus16_o, strobe_sel_o}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      wr(2'd2, 16'h000F);
      wr(2'd3, 16'h0007);
      wr(2'd0, {12'h0, e[39:36]});
      wr(2'd1, {8'h0, e[35:28]});
      wr(2'd2, {8'h0, e[27:20]});
      for (int b = 0; b < int'(e[19:16]); b++) begin
        beat_i = 1'b1;
        @(negedge clk);
      end
      beat_i = 1'b0;
      case (e[15:12])
        4'd1: begin ext_eot_i = 1'b1; @(negedge clk); ext_eot_i = 1'b0; end
        4'd2: begin short_pkt_i = 1'b1; @(negedge clk); short_pkt_i = 1'b0; end
        4'd3: wr(2'd2, 16'h000F);
        4'd4: begin ext_eot_i = 1'b1; short_pkt_i = 1'b1; @(negedge clk);
                    ext_eot_i = 1'b0; short_pkt_i = 1'b0; end
        default: @(negedge clk);
      endcase
      @(negedge clk);
      chk($sformatf("vec%0d R1/R11 req", v), dma_req_o, e[11]);
      chk($sformatf("vec%0d R4/R6/R7/R8/R9 reason", v), irq_reason_o, e[10:8]);
      chk($sformatf("vec%0d R3/R5 count", v), count_o, e[7:0]);
    end

    // R2 capture, R11 writes ignored while running
    wr(2'd2, 16'h000F);
    wr(2'd3, 16'h0007);
    wr(2'd0, 16'h000C);
    wr(2'd1, 16'd8);
    wr(2'd2, 16'h0007);
    chk("R2 strobe", strobe_sel_o, 2'b10);
    chk("R2 width/master/dir", {bus16_o, ata_mode_o, dir_wr_o}, 3'b111);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0000);
    chk("R2 held after cfg write", {strobe_sel_o, bus16_o}, 3'b101);
    chk("R11 count write ignored", count_o, 8);
    chk("R11 cmd ignored", {dma_req_o, ata_mode_o, dir_wr_o}, 3'b111);
    wr(2'd2, 16'h000F);
    chk("R8 stop ends", dma_req_o, 0);

    // R10 set beats clear in same cycle, then clear
    wr(2'd1, 16'd1);
    wr(2'd2, 16'h0000);
    @(negedge clk);
    beat_i = 1'b1; reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0007;
    @(negedge clk);
    beat_i = 1'b0; reg_we = 1'b0;
    chk("R10 set wins", {irq_o, irq_reason_o}, 4'b1100);
    @(negedge clk);
    chk("R10 sticky", irq_reason_o, 3'b100);
    wr(2'd3, 16'h0004);
    chk("R10 cleared", {irq_o, irq_reason_o}, 0);

    // R11 back-to-back command after termination
    wr(2'd1, 16'd10);
    wr(2'd2, 16'h0000);
    short_pkt_i = 1'b1;
    @(negedge clk);
    short_pkt_i = 1'b0;
    chk("R7 ended", dma_req_o, 0);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R11 restart", {dma_req_o, dir_wr_o}, 2'b11);
    wr(2'd2, 16'h000F);

    // R6 R7 events while idle ignored
    wr(2'd3, 16'h0007);
    ext_eot_i = 1'b1; short_pkt_i = 1'b1;
    @(negedge clk);
    ext_eot_i = 1'b0; short_pkt_i = 1'b0;
    @(negedge clk);
    chk("R6 R7 idle events", {dma_req_o, irq_reason_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule